// File: doc/BRIEF.md
# Dual Sample Queue with Threshold, Fault and DMA Request Logic

The block holds two first-in first-out queues of 12-bit conversion results. A converter pushes each sample into one of the two queues. A CPU or a DMA engine drains the queues through a shared read port. The most significant address bit of that port picks the queue and the remaining address bits are ignored. Each read moves that queue's read pointer forward by one, so a burst of reads at any addresses inside one half of the window returns consecutive samples.

Each queue has a programmable interrupt threshold and a programmable DMA request level. It also has three sticky status flags: threshold reached, overrun and underflow. Each flag has its own enable bit, and writing 1 to a flag clears it. An overrun or underflow locks the affected queue in a fault state. The fault state is left only when the module enable is taken low and then high again. Taking the enable low also empties both queues and raises an idle output.

Top module: `smpf_pair`

## Requirements
- R1: After reset, both word counts, all status flags, all interrupt enables and both DMA enables read 0. Both thresholds and both DMA levels read 63. `irq` and `dma_req` are 0.
- R2: Each queue returns its samples in write order. Its word count register always equals the number of samples it holds, from 0 to 64.
- R3: At every clock edge where a queue's word count is greater than or equal to its threshold, the queue's threshold flag is set. The flag bit is 3*q for queue q, in the status register at address 0. It stays set after the count falls again.
- R4: Writing to status address 0 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0. If a flag's set condition holds in the same cycle as its clear, the flag stays set.
- R5: `irq` is 1 exactly when some status bit and the same bit of the enable register at address 1 are both 1.
- R6: A push into a full queue (64 words) sets the overrun flag, bit 3*q+1. The sample is dropped and the queue enters the fault state.
- R7: A read from an empty queue returns 0, sets the underflow flag, bit 3*q+2, and puts the queue in the fault state.
- R8: While a queue is in the fault state, pushes to it are dropped. Reads from it return 0, do not move its count, and set no further flags. Its `dma_req` is 0. The other queue keeps working.
- R9: While `mod_en` is 0, `idle` is 1, both counts are 0, pushes are ignored and any fault state is cleared. Status flags keep their values.
- R10: `dma_req[q]` is 1 exactly when bit q of the DMA enable register (address 2) is 1, `mod_en` is 1, queue q is not in the fault state, and its count is at least its DMA level (address 6+q). It drops in the cycle the count falls below that level.
- R11: Read address bit 7 selects queue 0 (value 0) or queue 1 (value 1). Bits 6:0 have no effect. Thresholds are at address 4+q and counts at address 8+q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low empties the queues and clears faults |
| idle | output | 1 | High while the module is disabled |
| smp_we | input | 1 | Sample push strobe |
| smp_sel | input | 1 | Queue that receives the pushed sample |
| smp_data | input | 12 | Sample value |
| rd_en | input | 1 | Read strobe; advances the selected queue |
| rd_addr | input | 8 | Read address; MSB selects the queue |
| rd_data | output | 12 | Head sample of the selected queue, or 0 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| dma_req | output | 2 | Per-queue DMA request level |

## Verification
A wrong pointer or count shows up within one read as a sample out of order or a count register off by one. That is why every push and every read over a full 64-word fill and drain is compared. A flag that sets or clears in the wrong cycle is visible on `irq` and the status register at the first sample point after the edge, so the status register is read after each push. A fault that is lost or latched wrongly shows up on the next push or read to that queue: the count moves, or a read returns a nonzero value, when it should not.

// File: rtl/smpf_pkg.sv
package smpf_pkg;
   localparam int ST_THR  = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_UND  = 2;
   localparam int ST_BITS = 3;

   localparam int A_STATUS = 0;
   localparam int A_IRQEN  = 1;
   localparam int A_DMAEN  = 2;
   localparam int A_THR0   = 4;
   localparam int A_LVL0   = 6;
   localparam int A_CNT0   = 8;
endpackage

// File: rtl/smpf_queue.sv
module smpf_queue #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = PW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     count,
   output logic              fault,
   output logic              live,
   output logic              ovr_ev,
   output logic              und_ev
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wptr, rptr;
   logic              full, empty, wr_ok, rd_ok;

   assign live   = enable && !fault;
   assign full   = (count == CW'(DEPTH));
   assign empty  = (count == '0);
   assign wr_ok  = live && wr_req && !full;
   assign rd_ok  = live && rd_req && !empty;
   assign ovr_ev = live && wr_req && full;
   assign und_ev = live && rd_req && empty;
   assign rd_data = (live && !empty) ? mem[rptr] : '0;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         fault <= 1'b0;
      end else if (!enable) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         fault <= 1'b0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
         count <= count + CW'(wr_ok) - CW'(rd_ok);
         if (ovr_ev || und_ev) fault <= 1'b1;
      end
   end

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && fault) |=> (fault || !enable));
   assert_fault_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && fault && $past(enable && fault)) |-> $stable(count));
   assert_disable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (count == '0 && !fault));
endmodule

// File: rtl/smpf_csr.sv
module smpf_csr
   import smpf_pkg::*;
#(
   parameter int NQ     = 2,
   parameter int CW     = 7,
   parameter int LVL_W  = 6,
   parameter int REG_AW = 4,
   parameter int REG_DW = 16,
   localparam int SW    = NQ * ST_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [REG_AW-1:0]      reg_addr,
   input  logic [REG_DW-1:0]      reg_wdata,
   output logic [REG_DW-1:0]      reg_rdata,
   input  logic [NQ-1:0][CW-1:0]  q_count,
   input  logic [NQ-1:0]          q_live,
   input  logic [NQ-1:0]          q_ovr,
   input  logic [NQ-1:0]          q_und,
   output logic                   irq,
   output logic [NQ-1:0]          dma_req
);
   logic [SW-1:0]              status, irq_en, st_set, st_clr;
   logic [NQ-1:0]              dma_en;
   logic [NQ-1:0][LVL_W-1:0]   thr, lvl;
   logic                       unused_wdata;

   assign unused_wdata = ^reg_wdata;
   assign st_clr = (reg_we && reg_addr == REG_AW'(A_STATUS)) ? reg_wdata[SW-1:0] : '0;
   assign irq    = |(status & irq_en);

   for (genvar q = 0; q < NQ; q++) begin : g_q
      assign st_set[q*ST_BITS+ST_THR] = (q_count[q] >= CW'(thr[q]));
      assign st_set[q*ST_BITS+ST_OVR] = q_ovr[q];
      assign st_set[q*ST_BITS+ST_UND] = q_und[q];
      assign dma_req[q] = dma_en[q] && q_live[q] && (q_count[q] >= CW'(lvl[q]));

      assert_ovr_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         q_ovr[q] |=> status[q*ST_BITS+ST_OVR]);
      assert_und_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
         q_und[q] |=> status[q*ST_BITS+ST_UND]);
   end

   for (genvar b = 0; b < SW; b++) begin : g_bit
      assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (status[b] && !st_clr[b]) |=> status[b]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         irq_en <= '0;
         dma_en <= '0;
         thr    <= '1;
         lvl    <= '1;
      end else begin
         status <= (status & ~st_clr) | st_set;
         if (reg_we && reg_addr == REG_AW'(A_IRQEN)) irq_en <= reg_wdata[SW-1:0];
         if (reg_we && reg_addr == REG_AW'(A_DMAEN)) dma_en <= reg_wdata[NQ-1:0];
         for (int q = 0; q < NQ; q++) begin
            if (reg_we && reg_addr == REG_AW'(A_THR0 + q)) thr[q] <= reg_wdata[LVL_W-1:0];
            if (reg_we && reg_addr == REG_AW'(A_LVL0 + q)) lvl[q] <= reg_wdata[LVL_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(A_STATUS)) reg_rdata[SW-1:0] = status;
      if (reg_addr == REG_AW'(A_IRQEN))  reg_rdata[SW-1:0] = irq_en;
      if (reg_addr == REG_AW'(A_DMAEN))  reg_rdata[NQ-1:0] = dma_en;
      for (int q = 0; q < NQ; q++) begin
         if (reg_addr == REG_AW'(A_THR0 + q)) reg_rdata[LVL_W-1:0] = thr[q];
         if (reg_addr == REG_AW'(A_LVL0 + q)) reg_rdata[LVL_W-1:0] = lvl[q];
         if (reg_addr == REG_AW'(A_CNT0 + q)) reg_rdata[CW-1:0]    = q_count[q];
      end
   end
endmodule

// File: rtl/smpf_pair.sv
module smpf_pair
   import smpf_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64,
   parameter int LVL_W  = 6,
   parameter int RD_AW  = 8,
   parameter int REG_AW = 4,
   parameter int REG_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   output logic              idle,
   input  logic              smp_we,
   input  logic              smp_sel,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              rd_en,
   input  logic [RD_AW-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              irq,
   output logic [1:0]        dma_req
);
   localparam int NQ = 2;
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH != (1 << PW)) begin : g_chk_depth
      $error("smpf_pair: DEPTH must be a power of two");
   end
   if (LVL_W > CW) begin : g_chk_lvl
      $error("smpf_pair: LVL_W wider than the word count");
   end
   if (REG_DW < NQ * ST_BITS || REG_DW < CW || RD_AW < 1) begin : g_chk_bus
      $error("smpf_pair: register or read bus too narrow");
   end

   logic [NQ-1:0][CW-1:0]     q_count;
   logic [NQ-1:0][DATA_W-1:0] q_data;
   logic [NQ-1:0]             q_live, q_fault, q_ovr, q_und;
   logic                      rd_sel;
   logic                      unused_rd_low;

   assign rd_sel        = rd_addr[RD_AW-1];
   assign unused_rd_low = ^{rd_addr, q_fault};
   assign idle          = !mod_en;
   assign rd_data       = q_data[rd_sel];

   for (genvar q = 0; q < NQ; q++) begin : g_queue
      smpf_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
         .clk     (clk),
         .rst_n   (rst_n),
         .enable  (mod_en),
         .wr_req  (smp_we && (smp_sel == 1'(q))),
         .wr_data (smp_data),
         .rd_req  (rd_en && (rd_sel == 1'(q))),
         .rd_data (q_data[q]),
         .count   (q_count[q]),
         .fault   (q_fault[q]),
         .live    (q_live[q]),
         .ovr_ev  (q_ovr[q]),
         .und_ev  (q_und[q])
      );
   end

   smpf_csr #(
      .NQ(NQ), .CW(CW), .LVL_W(LVL_W), .REG_AW(REG_AW), .REG_DW(REG_DW)
   ) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .q_count   (q_count),
      .q_live    (q_live),
      .q_ovr     (q_ovr),
      .q_und     (q_und),
      .irq       (irq),
      .dma_req   (dma_req)
   );

   assert_dma_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|dma_req) |-> mod_en);
   assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (q_count == '0 || mod_en));
endmodule

// File: tb/smpf_pair_test.sv
module smpf_pair_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_en = 1'b0;
   logic        idle;
   logic        smp_we = 1'b0;
   logic        smp_sel = 1'b0;
   logic [11:0] smp_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [11:0] rd_data;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;
   logic [1:0]  dma_req;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smpf_pair uut (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .idle(idle),
      .smp_we(smp_we), .smp_sel(smp_sel), .smp_data(smp_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .dma_req(dma_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rreg(input int a, output int v);
      reg_addr = 4'(a);
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic wreg(input int a, input int d);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic push(input int sel, input int d);
      smp_we = 1'b1; smp_sel = 1'(sel); smp_data = 12'(d);
      @(negedge clk);
      smp_we = 1'b0;
   endtask

   task automatic pop(input int a, output int d);
      rd_en = 1'b1; rd_addr = 8'(a);
      #1;
      d = int'(rd_data);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v, d;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 irq", int'(irq), 0);
      chk("R1 dma_req", int'(dma_req), 0);
      chk("R9 idle while disabled", int'(idle), 1);
      rst_n = 1'b1;
      @(negedge clk);
      rreg(0, v); chk("R1 status", v, 0);
      rreg(1, v); chk("R1 irq enables", v, 0);
      rreg(2, v); chk("R1 dma enables", v, 0);
      for (int q = 0; q < 2; q++) begin
         rreg(4 + q, v); chk("R1 threshold", v, 63);
         rreg(6 + q, v); chk("R1 dma level", v, 63);
         rreg(8 + q, v); chk("R1 count", v, 0);
      end
      mod_en = 1'b1;
      @(negedge clk);
      chk("R9 idle when enabled", int'(idle), 0);

      // R2 R3 R5 R10: fill queue 0 completely
      wreg(4, 5);
      wreg(6, 10);
      wreg(1, 16'h3F);
      wreg(2, 1);
      for (int i = 0; i < 64; i++) begin
         push(0, (i * 37 + 5) & 12'hFFF);
         rreg(8, v); chk("R2 count on fill", v, i + 1);
         rreg(0, v); chk("R3 threshold flag", v & 1, (i >= 5) ? 1 : 0);
         chk("R5 irq follows flag", int'(irq), (i >= 5) ? 1 : 0);
         chk("R10 dma on fill", int'(dma_req[0]), (i + 1 >= 10) ? 1 : 0);
      end
      // R2 R11: drain with varying low address bits
      for (int j = 0; j < 64; j++) begin
         pop((j * 5) & 8'h7F, d);
         chk("R11 R2 data order", d, (j * 37 + 5) & 12'hFFF);
         rreg(8, v); chk("R2 count on drain", v, 63 - j);
         chk("R10 dma on drain", int'(dma_req[0]), (63 - j >= 10) ? 1 : 0);
      end
      rreg(0, v); chk("R3 flag sticky after drain", v & 1, 1);
      wreg(0, 0);
      rreg(0, v); chk("R4 write 0 keeps flag", v & 1, 1);
      wreg(0, 1);
      rreg(0, v); chk("R4 write 1 clears flag", v, 0);
      chk("R5 irq low when no flag", int'(irq), 0);

      // R11: queue 1 through the address MSB
      for (int k = 0; k < 3; k++) push(1, 12'hA00 + k);
      rreg(8, v); chk("R11 queue 0 untouched", v, 0);
      rreg(9, v); chk("R11 queue 1 count", v, 3);
      for (int k = 0; k < 3; k++) begin
         pop(8'h80 | ((k * 29) & 8'h7F), d);
         chk("R11 queue 1 data", d, 12'hA00 + k);
      end

      // R6: overrun on queue 1
      for (int k = 0; k < 64; k++) push(1, k);
      rreg(9, v); chk("R2 queue 1 full", v, 64);
      rreg(0, v); chk("R6 no overrun yet", (v >> 4) & 1, 0);
      push(1, 12'hFFF);
      rreg(0, v); chk("R6 overrun flag", (v >> 4) & 1, 1);
      rreg(9, v); chk("R6 sample dropped", v, 64);
      // R8: fault behaviour
      push(1, 12'h111);
      rreg(9, v); chk("R8 push dropped in fault", v, 64);
      pop(8'h80, d);
      chk("R8 read zero in fault", d, 0);
      rreg(9, v); chk("R8 count frozen", v, 64);
      rreg(0, v); chk("R8 no underflow in fault", (v >> 5) & 1, 0);
      wreg(7, 0);
      wreg(2, 2);
      chk("R8 no dma in fault", int'(dma_req[1]), 0);
      push(0, 12'h123);
      pop(8'h00, d);
      chk("R8 other queue works", d, 12'h123);

      // R9: disable/enable cycle
      mod_en = 1'b0;
      @(negedge clk);
      chk("R9 idle", int'(idle), 1);
      rreg(9, v); chk("R9 count cleared", v, 0);
      rreg(0, v); chk("R9 status kept", (v >> 4) & 1, 1);
      chk("R10 no dma while disabled", int'(dma_req[1]), 0);
      push(0, 12'h222);
      rreg(8, v); chk("R9 push ignored while disabled", v, 0);
      mod_en = 1'b1;
      @(negedge clk);
      chk("R9 idle low after enable", int'(idle), 0);
      chk("R10 dma at level 0", int'(dma_req[1]), 1);
      push(1, 12'h5A5);
      pop(8'h80 | 8'h33, d);
      chk("R9 queue 1 recovered", d, 12'h5A5);

      // R7: underflow on queue 0
      pop(8'h11, d);
      chk("R7 empty read zero", d, 0);
      rreg(0, v); chk("R7 underflow flag", (v >> 2) & 1, 1);
      push(0, 12'h777);
      rreg(8, v); chk("R8 underflow fault drops push", v, 0);

      // R4: set wins over clear
      wreg(4, 0);
      @(negedge clk);
      rreg(0, v); chk("R3 threshold zero sets", v & 1, 1);
      wreg(0, 1);
      rreg(0, v); chk("R4 set beats clear", v & 1, 1);

      // R5: masking
      wreg(1, 0);
      chk("R5 irq masked", int'(irq), 0);
      wreg(1, 16'h10);
      chk("R5 irq by overrun enable", int'(irq), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule